// File: doc/BRIEF.md
# Dual-Channel Sampling ADC Readout Controller

This block sequences a dual-channel, 14-bit converter that has one shared start-convert line, one shared busy (end-of-conversion) status line and one tri-state parallel data bus. A single start pulse makes both channels sample at the same instant. The controller then waits for the busy line to fall and reads the bus twice, first channel A and then channel B. It selects each channel by pulling that channel's active-low output enable and holds it low long enough to cover the converter's enable-to-data access time.

Each finished pair of results is offered downstream on a valid/ready stream. The results can be passed through as offset binary or converted to two's complement by flipping the top bit. Conversions repeat at a programmable start-to-start interval in clock cycles. The interval is clamped so that the converter's maximum sample rate is never exceeded. If a new pair arrives while the previous one is still waiting, the older pair is dropped and a sticky overrun flag is raised.

The state machine has these states: IDLE (waiting for `run_en`), START (start line high), CONV (waiting for busy to fall), READ_A (channel A enable low), GAP (both enables high), READ_B (channel B enable low) and HOLD (waiting for the next start slot). The transitions are:
- IDLE→START when `run_en` is high and the rate timer is due.
- START→CONV after the pulse-width count.
- CONV→READ_A when busy is low.
- READ_A→GAP after the access count.
- GAP→READ_B after one cycle.
- READ_B→HOLD after the access count.
- HOLD→START when due while running.
- HOLD→IDLE when `run_en` is low.

Top module: `dual_adc_reader`

## Requirements
- R1: Each start pulse is high for exactly ceil(START_MIN_NS/CLK_NS) cycles. This is 13 cycles with the defaults (100 ns minimum, 8 ns clock).
- R2: While running with a short conversion, consecutive rising edges of `conv_start` are max(`interval_cyc`, ceil(MIN_PERIOD_NS/CLK_NS)) cycles apart. The minimum is 63 cycles with the defaults (500 ns). They are never closer than that minimum.
- R3: After a start pulse, no enable goes low until `conv_busy` has been seen low. The read then takes busy-fall + 2·ACC_CYC + 3 cycles from the start edge. The next start therefore comes at max(R2 gap, L + 23) cycles when busy is low L cycles after the start edge, with the defaults.
- R4: Channel A is read before channel B. Each enable stays low for ACC_CYC = ceil(ACCESS_NS/CLK_NS) cycles (10 by default), and the bus is latched at the end of that window.
- R5: `oe_a_n` and `oe_b_n` are never low together, and both are high for at least one cycle between the A read and the B read.
- R6: With `signed_mode` = 0, `out_a` and `out_b` carry the 14-bit bus codes unchanged (offset binary: 14'h2000 is zero input, 14'h3FFF is +FS−1LSB, 14'h0000 is −FS).
- R7: With `signed_mode` = 1, bit 13 of each code is inverted. This maps 14'h2000→14'h0000, 14'h3FFF→14'h1FFF and 14'h0000→14'h2000. The mode is sampled when the pair is loaded.
- R8: While `out_valid` is high and `out_ready` is low, `out_a`, `out_b` and `out_valid` hold steady. A cycle with both high consumes the pair.
- R9: If a new pair is loaded while the previous one is still valid and not accepted, `overrun` goes high and stays high until reset, and the newer pair replaces the older one.
- R10: Reset leaves `conv_start` low, both enables high, `out_valid` low and `overrun` low. No start is issued while `run_en` is low. Dropping `run_en` lets the current conversion finish and deliver its pair, and then no further start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Enables repeated conversions |
| signed_mode | input | 1 | 1: two's-complement output, 0: offset binary |
| interval_cyc | input | 16 | Requested start-to-start interval in cycles |
| conv_start | output | 1 | Start-convert pulse to both channels |
| conv_busy | input | 1 | High while a conversion is in progress |
| oe_a_n | output | 1 | Channel A output enable, active low |
| oe_b_n | output | 1 | Channel B output enable, active low |
| bus_data | input | 14 | Shared converter data bus |
| out_valid | output | 1 | Result pair available |
| out_ready | input | 1 | Downstream accepts the pair |
| out_a | output | 14 | Channel A result |
| out_b | output | 14 | Channel B result |
| overrun | output | 1 | Sticky: a pair was dropped |

## Verification
The assertions assume that `conv_busy` is synchronous to `clk` and rises before the start pulse ends. They also assume that the bus carries valid data within ACCESS_NS of an enable falling, and that `signed_mode` and `interval_cyc` change only while the controller is idle. The bench's converter model raises busy one cycle after it sees the start edge and keeps it high for a chosen length. It drives a deliberately wrong pattern for the first 75 ns after an enable falls and only then the true code. Settings are changed only after `run_en` has been dropped and the pipeline has drained.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_CONV,
        ST_READ_A,
        ST_GAP,
        ST_READ_B,
        ST_HOLD
    } rd_state_t;

    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/adc_rate_timer.sv
`timescale 1ns/1ps
module adc_rate_timer #(
    parameter int IW      = 16,
    parameter int MIN_GAP = 63
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [IW-1:0] interval_cyc,
    output logic          due
);
    localparam logic [IW-1:0] MIN_GAP_V = IW'(MIN_GAP);

    logic [IW-1:0] elapsed_q;
    logic [IW-1:0] eff_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '1;
        end else if (launch) begin
            elapsed_q <= '0;
        end else if (elapsed_q != '1) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    always_comb begin
        eff_gap = (interval_cyc < MIN_GAP_V) ? MIN_GAP_V : interval_cyc;
        due     = (elapsed_q >= eff_gap - 1'b1);
    end

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_rd_pkg::*;
#(
    parameter int DW        = 14,
    parameter int START_CYC = 13,
    parameter int ACC_CYC   = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          due,
    input  logic          conv_busy,
    input  logic [DW-1:0] bus_data,
    output logic          conv_start,
    output logic          oe_a_n,
    output logic          oe_b_n,
    output logic          launch,
    output logic          pair_load,
    output logic [DW-1:0] raw_a,
    output logic [DW-1:0] raw_b
);
    localparam int CNT_MAX = (START_CYC > ACC_CYC) ? START_CYC : ACC_CYC;
    localparam int CW      = $clog2(CNT_MAX + 2);

    rd_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          start_done, acc_done;

    assign start_done = (cnt_q == CW'(START_CYC - 1));
    assign acc_done   = (cnt_q == CW'(ACC_CYC - 1));

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run_en && due) state_d = ST_START;
            ST_START:  if (start_done)    state_d = ST_CONV;
            ST_CONV:   if (!conv_busy)    state_d = ST_READ_A;
            ST_READ_A: if (acc_done)      state_d = ST_GAP;
            ST_GAP:                       state_d = ST_READ_B;
            ST_READ_B: if (acc_done)      state_d = ST_HOLD;
            ST_HOLD: begin
                if (!run_en)  state_d = ST_IDLE;
                else if (due) state_d = ST_START;
            end
            default:                      state_d = ST_IDLE;
        endcase
    end

    // state register and dwell counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // bus capture at the end of each access window
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_a     <= '0;
            raw_b     <= '0;
            pair_load <= 1'b0;
        end else begin
            if (state_q == ST_READ_A && acc_done) raw_a <= bus_data;
            if (state_q == ST_READ_B && acc_done) raw_b <= bus_data;
            pair_load <= (state_q == ST_READ_B) && acc_done;
        end
    end

    // outputs decoded from state
    always_comb begin
        conv_start = (state_q == ST_START);
        oe_a_n     = (state_q != ST_READ_A);
        oe_b_n     = (state_q != ST_READ_B);
        launch     = (state_q != ST_START) && (state_d == ST_START);
    end

    // checking aid: length of the current high run of conv_start
    logic [CW:0] hi_len_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len_q <= '0;
        end else if (conv_start) begin
            if (hi_len_q != '1) hi_len_q <= hi_len_q + 1'b1;
        end else begin
            hi_len_q <= '0;
        end
    end

    AST_START_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_start) |-> (hi_len_q >= (CW+1)'(START_CYC))); // R1

    AST_READ_AFTER_EOC: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_a_n) |-> !$past(conv_busy)); // R3

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        oe_a_n || oe_b_n); // R5

    AST_ENABLE_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_b_n) |-> $past(oe_a_n)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !run_en) |=> !conv_start); // R10

endmodule

// File: rtl/adc_out_stage.sv
`timescale 1ns/1ps
module adc_out_stage #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          signed_mode,
    input  logic [DW-1:0] raw_a,
    input  logic [DW-1:0] raw_b,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic          overrun
);
    function automatic logic [DW-1:0] recode(input logic [DW-1:0] c, input logic s);
        return s ? {~c[DW-1], c[DW-2:0]} : c;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
            overrun   <= 1'b0;
        end else if (load) begin
            if (out_valid && !out_ready) overrun <= 1'b1;
            out_valid <= 1'b1;
            out_a     <= recode(raw_a, signed_mode);
            out_b     <= recode(raw_b, signed_mode);
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_a) && $stable(out_b))); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R9

endmodule

// File: rtl/dual_adc_reader.sv
`timescale 1ns/1ps
module dual_adc_reader
    import adc_rd_pkg::*;
#(
    parameter int DW            = 14,
    parameter int IW            = 16,
    parameter int CLK_NS        = 8,
    parameter int START_MIN_NS  = 100,
    parameter int MIN_PERIOD_NS = 500,
    parameter int ACCESS_NS     = 75
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          signed_mode,
    input  logic [IW-1:0] interval_cyc,
    output logic          conv_start,
    input  logic          conv_busy,
    output logic          oe_a_n,
    output logic          oe_b_n,
    input  logic [DW-1:0] bus_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic          overrun
);
    localparam int START_CYC = ns_to_cycles(START_MIN_NS, CLK_NS);
    localparam int MIN_GAP   = ns_to_cycles(MIN_PERIOD_NS, CLK_NS);
    localparam int ACC_CYC   = ns_to_cycles(ACCESS_NS, CLK_NS);

    logic          launch, due, pair_load;
    logic [DW-1:0] raw_a, raw_b;

    adc_rate_timer #(.IW(IW), .MIN_GAP(MIN_GAP)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .interval_cyc (interval_cyc),
        .due          (due)
    );

    adc_seq_fsm #(.DW(DW), .START_CYC(START_CYC), .ACC_CYC(ACC_CYC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .due        (due),
        .conv_busy  (conv_busy),
        .bus_data   (bus_data),
        .conv_start (conv_start),
        .oe_a_n     (oe_a_n),
        .oe_b_n     (oe_b_n),
        .launch     (launch),
        .pair_load  (pair_load),
        .raw_a      (raw_a),
        .raw_b      (raw_b)
    );

    adc_out_stage #(.DW(DW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .load        (pair_load),
        .signed_mode (signed_mode),
        .raw_a       (raw_a),
        .raw_b       (raw_b),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_a       (out_a),
        .out_b       (out_b),
        .overrun     (overrun)
    );

    // checking aid: cycles since the last rising edge of conv_start
    logic          start_q;
    logic [IW-1:0] since_rise_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q      <= 1'b0;
            since_rise_q <= '1;
        end else begin
            start_q <= conv_start;
            if (conv_start && !start_q) begin
                since_rise_q <= IW'(1);
            end else if (since_rise_q != '1) begin
                since_rise_q <= since_rise_q + 1'b1;
            end
        end
    end

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !start_q) |-> (since_rise_q >= IW'(MIN_GAP))); // R2

endmodule

// File: tb/dual_adc_reader_bench.sv
`timescale 1ns/1ps
module dual_adc_reader_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] interval_cyc = 16'd63;
    logic        conv_start, oe_a_n, oe_b_n, out_valid, overrun;
    logic        out_ready = 1'b1;
    logic [13:0] out_a, out_b;
    logic        conv_busy = 1'b0;
    wire  [13:0] bus;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dual_adc_reader u_dual_adc_reader (
        .clk(clk), .rst(rst), .run_en(run_en), .signed_mode(signed_mode),
        .interval_cyc(interval_cyc), .conv_start(conv_start), .conv_busy(conv_busy),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_data(bus), .out_valid(out_valid),
        .out_ready(out_ready), .out_a(out_a), .out_b(out_b), .overrun(overrun)
    );

    // ---------------- converter model ----------------
    function automatic logic [13:0] a_val(input int k);
        case (k % 16)
            0: return 14'h0000;
            1: return 14'h3FFF;
            2: return 14'h2000;
            3: return 14'h1FFF;
            default: return 14'((k * 4099 + 77) & 16'h3FFF);
        endcase
    endfunction

    function automatic logic [13:0] b_val(input int k);
        return a_val(k) ^ 14'h3FFF;
    endfunction

    int          conv_cnt = 0;
    int          conv_len = 30;
    int          bcnt = 0;
    logic        cv_start_q = 1'b0;
    logic [13:0] cur_a = '0, cur_b = '0;
    logic        drv_a = 1'b0, drv_b = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            cv_start_q <= 1'b0;
            conv_busy  <= 1'b0;
        end else begin
            cv_start_q <= conv_start;
            if (conv_start && !cv_start_q) begin
                cur_a     <= a_val(conv_cnt);
                cur_b     <= b_val(conv_cnt);
                conv_cnt  <= conv_cnt + 1;
                conv_busy <= 1'b1;
                bcnt      <= conv_len - 2;
            end else if (conv_busy) begin
                if (bcnt == 0) conv_busy <= 1'b0;
                else bcnt <= bcnt - 1;
            end
        end
    end

    always @(oe_a_n) begin
        if (oe_a_n) drv_a = 1'b0;
        else begin #75; drv_a = !oe_a_n; end
    end

    always @(oe_b_n) begin
        if (oe_b_n) drv_b = 1'b0;
        else begin #75; drv_b = !oe_b_n; end
    end

    assign bus = drv_a ? cur_a :
                 drv_b ? cur_b :
                 (!oe_a_n || !oe_b_n) ? 14'h2AAA : 14'bz;

    // ---------------- port monitor ----------------
    int   cyc = 0, rise_cyc = 0, last_gap = 0, hi = 0, last_width = 0, start_rises = 0;
    int   clash = 0, gap_bad = 0;
    logic mon_start_q = 1'b0, mon_oea_q = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (conv_start && !mon_start_q) begin
            start_rises++;
            last_gap = cyc - rise_cyc;
            rise_cyc = cyc;
        end
        if (conv_start) hi++;
        else if (mon_start_q) begin last_width = hi; hi = 0; end
        mon_start_q = conv_start;
        if (!oe_a_n && !oe_b_n) clash++;
        if (!oe_b_n && !mon_oea_q) gap_bad++;
        mon_oea_q = oe_a_n;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_pairs(input int n, input int ivl, input int len, input logic sgn);
        int rx;
        int exp_gap;
        int n0;
        interval_cyc = 16'(ivl);
        conv_len     = len;
        signed_mode  = sgn;
        out_ready    = 1'b1;
        rx           = conv_cnt;
        exp_gap      = (ivl < 63) ? 63 : ivl;
        if (len + 23 > exp_gap) exp_gap = len + 23;
        run_en = 1'b1;
        for (int j = 0; j < n; j++) begin
            do @(negedge clk); while (!out_valid);
            if (sgn) begin
                check("R7 out_a", 32'(out_a), 32'(a_val(rx) ^ 14'h2000));
                check("R7 out_b", 32'(out_b), 32'(b_val(rx) ^ 14'h2000));
            end else begin
                check("R6 out_a (R4 A first)", 32'(out_a), 32'(a_val(rx)));
                check("R6 out_b (R4 B second)", 32'(out_b), 32'(b_val(rx)));
            end
            if (j >= 1) begin
                check("R2/R3 start gap", 32'(last_gap), 32'(exp_gap));
                check("R1 start width", 32'(last_width), 32'd13);
            end
            rx++;
        end
        run_en = 1'b0;
        repeat (120) @(negedge clk);
        n0 = start_rises;
        repeat (100) @(negedge clk);
        check("R10 no start after run_en drop", 32'(start_rises), 32'(n0));
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int c0;
        int n0;
        logic [13:0] held_a;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset conv_start", 32'(conv_start), 32'd0);
        check("R10 reset oe_a_n", 32'(oe_a_n), 32'd1);
        check("R10 reset oe_b_n", 32'(oe_b_n), 32'd1);
        check("R10 reset out_valid", 32'(out_valid), 32'd0);
        check("R10 reset overrun", 32'(overrun), 32'd0);
        n0 = start_rises;
        repeat (100) @(negedge clk);
        check("R10 idle without run_en", 32'(start_rises), 32'(n0));

        run_pairs(16, 63, 30, 1'b0);
        run_pairs(16, 10, 30, 1'b1);
        run_pairs(6, 200, 30, 1'b0);
        run_pairs(6, 10, 45, 1'b0);

        check("R5 enables never both low", 32'(clash), 32'd0);
        check("R5 gap between reads", 32'(gap_bad), 32'd0);
        check("R9 no overrun while ready", 32'(overrun), 32'd0);

        // overrun: two pairs with ready held low
        interval_cyc = 16'd63;
        conv_len     = 30;
        signed_mode  = 1'b0;
        out_ready    = 1'b0;
        c0           = conv_cnt;
        run_en       = 1'b1;
        while (conv_cnt != c0 + 2) @(negedge clk);
        run_en = 1'b0;
        repeat (150) @(negedge clk);
        check("R9 overrun raised", 32'(overrun), 32'd1);
        check("R10 pair after drop delivered", 32'(out_valid), 32'd1);
        check("R9 newer pair kept a", 32'(out_a), 32'(a_val(c0 + 1)));
        check("R9 newer pair kept b", 32'(out_b), 32'(b_val(c0 + 1)));
        held_a = out_a;
        repeat (5) @(negedge clk);
        check("R8 held while not ready", 32'(out_a), 32'(held_a));
        check("R8 valid held", 32'(out_valid), 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        check("R8 handshake clears valid", 32'(out_valid), 32'd0);
        check("R9 overrun sticky", 32'(overrun), 32'd1);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset clears overrun", 32'(overrun), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule